// File: doc/BRIEF.md
# SDRAM Bank Command Timing Guard

This block sits between the command issuer of a memory controller and a multi-bank SDR SDRAM device (two banks by default). It keeps the open or idle state of every bank and a set of saturating cycle counters. From these it decides, in the same cycle, whether a requested command may go to the device without breaking a minimum spacing rule. The requester offers one command per cycle on a valid/ready handshake. A command that is not granted stays on the request lines until the guard raises ready. A granted command appears on the issue outputs in that same cycle.

The block also drives the clock-enable pin. When the controller asks for clock suspend, the guard lowers CKE from the next cycle on. While CKE is low, all command grants and all timing counters are frozen. The device performs no refresh while suspended, so the guard limits how long one suspend may last. When that limit is reached it forces CKE high and holds a flag until the request is withdrawn. Separately, each bank has a flag that shows when the bank has stayed open longer than the maximum row-active time.

Top module: `sdram_cmd_guard`

## Requirements
- R1: ACTIVE (cmd code 1) to a bank is granted only if that bank is idle and at least T_RP cycles have passed since the edge that closed it. The bank reads as open from the cycle after the grant.
- R2: An ACTIVE is granted only if at least T_RRD cycles have passed since the previous ACTIVE to any bank, so two banks can be opened T_RRD cycles apart.
- R3: READ (code 2) and WRITE (code 3) to a bank are granted only when that bank is open and at least T_RCD cycles have passed since its ACTIVE. They are never granted to an idle bank.
- R4: PRECHARGE (code 4) to an open bank is granted only once T_RAS_MIN cycles have passed since its ACTIVE. READ with auto-precharge (code 5) and WRITE with auto-precharge (code 6) need both the T_RCD and the T_RAS_MIN spacing. All three close the bank from the next cycle.
- R5: ras_viol for a bank is high whenever the bank has been open for T_RAS_MAX or more unsuspended cycles, and low while the bank is idle.
- R6: If susp_req is high in a cycle, cke is low in the next cycle, unless the suspend limit lockout applies. If susp_req is low, cke is high in the next cycle.
- R7: While cke is low, no command is granted and every bank and spacing counter holds its value.
- R8: A suspend lasts at most T_SUSP_MAX consecutive cycles. After that, cke is driven high and susp_over stays high from the next cycle until susp_req is seen low. While susp_over is high, cke stays high.
- R9: After reset, both banks are idle, every minimum spacing is already met, cke is high, and susp_over and ras_viol are low.
- R10: NOP (code 0) and the reserved code 7 are always granted while cke is high and change nothing. A PRECHARGE to an idle bank is granted and changes nothing. issue_valid, issue_cmd and issue_bank show the handshake and the accepted command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request present |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BW | Target bank of the request |
| req_ready | output | 1 | Request may be issued this cycle |
| issue_valid | output | 1 | Command sent to the device this cycle |
| issue_cmd | output | 3 | Code of the command sent |
| issue_bank | output | BW | Bank of the command sent |
| susp_req | input | 1 | Controller asks for clock suspend |
| cke | output | 1 | Clock enable to the device |
| susp_over | output | 1 | Suspend limit reached, lockout active |
| bank_open | output | NUM_BANKS | Per-bank open state |
| ras_viol | output | NUM_BANKS | Per-bank maximum active time exceeded |

## Verification
The bench tests grants exactly at the edges of each spacing window. It targets the cycle in which the count reaches T_RP, T_RRD, T_RCD or T_RAS_MIN. An off-by-one counter would grant one cycle early or stall one cycle too long. Suspend bursts are made both shorter and longer than T_SUSP_MAX. A guard that let counters run during suspend, granted commands with CKE low, or failed to release the lockout would show a mismatch in ready or cke. A directed hold of an open bank past T_RAS_MAX checks that the violation flag rises in the correct cycle and falls on precharge.

// File: rtl/sguard_pkg.sv
package sguard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_RDA = 3'd5,
        CMD_WRA = 3'd6,
        CMD_RSV = 3'd7
    } cmd_e;

endpackage

// File: rtl/sguard_bank.sv
module sguard_bank #(
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RCD     = 3,
    parameter int unsigned T_RAS_MIN = 6,
    parameter int unsigned T_RAS_MAX = 7000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic do_act,
    input  logic do_rw,
    input  logic do_close,
    output logic is_open,
    output logic act_ok,
    output logic rw_ok,
    output logic close_ok,
    output logic ras_viol
);
    localparam int unsigned AW = $clog2(T_RAS_MAX + 1);
    localparam int unsigned PW = $clog2(T_RP + 1);

    typedef struct packed {
        logic          open;
        logic [AW-1:0] act_cnt;
        logic [PW-1:0] pre_cnt;
    } bank_s;

    bank_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!hold) begin
            if (do_act) begin
                s_d.open    = 1'b1;
                s_d.act_cnt = AW'(1);
            end else if (s_q.act_cnt < AW'(T_RAS_MAX)) begin
                s_d.act_cnt = s_q.act_cnt + AW'(1);
            end
            if (do_close) begin
                s_d.open    = 1'b0;
                s_d.pre_cnt = PW'(1);
            end else if (s_q.pre_cnt < PW'(T_RP)) begin
                s_d.pre_cnt = s_q.pre_cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.open    <= 1'b0;
            s_q.act_cnt <= '0;
            s_q.pre_cnt <= PW'(T_RP);
        end else begin
            s_q <= s_d;
        end
    end

    assign is_open  = s_q.open;
    assign act_ok   = !s_q.open && (s_q.pre_cnt >= PW'(T_RP));
    assign rw_ok    = s_q.open && (s_q.act_cnt >= AW'(T_RCD));
    assign close_ok = s_q.open && (s_q.act_cnt >= AW'(T_RAS_MIN));
    assign ras_viol = s_q.open && (s_q.act_cnt >= AW'(T_RAS_MAX));

    // R1: the top only opens a bank that is idle and recovered
    p_act_recovered_r1: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (!s_q.open && s_q.pre_cnt >= PW'(T_RP)));
    // R3: column access only after the row delay
    p_rw_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_rw |-> (s_q.open && s_q.act_cnt >= AW'(T_RCD)));
    // R4: closing only after the minimum active time
    p_close_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_close |-> (s_q.open && s_q.act_cnt >= AW'(T_RAS_MIN)));
    // R7: nothing reaches the bank while the clock is suspended
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(do_act || do_rw || do_close));
    // R4: a close leaves the bank idle
    p_closed_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_close && !hold) |=> !is_open);
endmodule

// File: rtl/sguard_susp.sv
module sguard_susp #(
    parameter int unsigned T_SUSP_MAX = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_req,
    output logic cke,
    output logic susp_over
);
    localparam int unsigned SW = $clog2(T_SUSP_MAX + 1);

    typedef struct packed {
        logic          cke;
        logic          lock;
        logic [SW-1:0] cnt;
    } susp_s;

    susp_s s_d, s_q;
    logic  limit_hit;

    always_comb begin
        s_d       = s_q;
        limit_hit = !s_q.cke && susp_req && (s_q.cnt == SW'(T_SUSP_MAX - 1));
        s_d.cke   = !(susp_req && !s_q.lock && !limit_hit);
        s_d.lock  = limit_hit || (s_q.lock && susp_req);
        if (s_q.cke) begin
            s_d.cnt = '0;
        end else if (s_q.cnt < SW'(T_SUSP_MAX)) begin
            s_d.cnt = s_q.cnt + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cke  <= 1'b1;
            s_q.lock <= 1'b0;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cke       = s_q.cke;
    assign susp_over = s_q.lock;

    // R8: a suspend never outlasts its limit
    p_susp_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cke |-> (s_q.cnt < SW'(T_SUSP_MAX)));
    // R8: the lockout keeps the clock running
    p_lock_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lock |-> s_q.cke);
    // R6: a request without lockout enters suspend next cycle
    p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_req && s_q.cke && !s_q.lock) |=> !cke);
    // R6: dropping the request resumes next cycle
    p_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !susp_req |=> (cke && !susp_over));
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sguard_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 2,
    parameter int unsigned T_RP       = 3,
    parameter int unsigned T_RRD      = 2,
    parameter int unsigned T_RCD      = 3,
    parameter int unsigned T_RAS_MIN  = 6,
    parameter int unsigned T_RAS_MAX  = 7000,
    parameter int unsigned T_SUSP_MAX = 2000,
    localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_cmd,
    input  logic [BW-1:0]        req_bank,
    output logic                 req_ready,
    output logic                 issue_valid,
    output logic [2:0]           issue_cmd,
    output logic [BW-1:0]        issue_bank,
    input  logic                 susp_req,
    output logic                 cke,
    output logic                 susp_over,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] ras_viol
);
    localparam int unsigned RW = $clog2(T_RRD + 1);

    typedef struct packed {
        logic [RW-1:0] rrd;
    } top_s;

    top_s t_d, t_q;

    logic [NUM_BANKS-1:0] act_ok, rw_ok, close_ok;
    logic [NUM_BANKS-1:0] do_act, do_rw, do_close;
    logic                 grant_ok, fire;
    cmd_e                 cmd;

    assign cmd = cmd_e'(req_cmd);

    always_comb begin
        unique case (cmd)
            CMD_ACT:          grant_ok = act_ok[req_bank] && (t_q.rrd >= RW'(T_RRD));
            CMD_RD, CMD_WR:   grant_ok = rw_ok[req_bank];
            CMD_PRE:          grant_ok = !bank_open[req_bank] || close_ok[req_bank];
            CMD_RDA, CMD_WRA: grant_ok = rw_ok[req_bank] && close_ok[req_bank];
            default:          grant_ok = 1'b1;
        endcase
    end

    assign req_ready   = cke && grant_ok;
    assign fire        = req_valid && req_ready;
    assign issue_valid = fire;
    assign issue_cmd   = req_cmd;
    assign issue_bank  = req_bank;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic sel;
            assign sel         = fire && (req_bank == BW'(b));
            assign do_act[b]   = sel && (cmd == CMD_ACT);
            assign do_rw[b]    = sel && (cmd == CMD_RD || cmd == CMD_WR ||
                                         cmd == CMD_RDA || cmd == CMD_WRA);
            assign do_close[b] = sel && ((cmd == CMD_PRE && bank_open[b]) ||
                                         cmd == CMD_RDA || cmd == CMD_WRA);

            sguard_bank #(
                .T_RP      (T_RP),
                .T_RCD     (T_RCD),
                .T_RAS_MIN (T_RAS_MIN),
                .T_RAS_MAX (T_RAS_MAX)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .hold     (!cke),
                .do_act   (do_act[b]),
                .do_rw    (do_rw[b]),
                .do_close (do_close[b]),
                .is_open  (bank_open[b]),
                .act_ok   (act_ok[b]),
                .rw_ok    (rw_ok[b]),
                .close_ok (close_ok[b]),
                .ras_viol (ras_viol[b])
            );

            // R1: a granted activate opens the bank
            p_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
                do_act[b] |=> bank_open[b]);
        end
    endgenerate

    always_comb begin
        t_d = t_q;
        if (cke) begin
            if (|do_act) begin
                t_d.rrd = RW'(1);
            end else if (t_q.rrd < RW'(T_RRD)) begin
                t_d.rrd = t_q.rrd + RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.rrd <= RW'(T_RRD);
        end else begin
            t_q <= t_d;
        end
    end

    sguard_susp #(
        .T_SUSP_MAX (T_SUSP_MAX)
    ) u_susp (
        .clk       (clk),
        .rst_n     (rst_n),
        .susp_req  (susp_req),
        .cke       (cke),
        .susp_over (susp_over)
    );

    // R2: activates stay T_RRD apart
    p_act_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|do_act) |-> (t_q.rrd >= RW'(T_RRD)));
    // R2: one activate per cycle at most
    p_single_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(do_act));
    // R7: no command leaves while suspended
    p_no_issue_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !issue_valid);
    // R5: an idle bank never flags a long-open violation
    p_viol_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_viol & ~bank_open) == '0);
endmodule

// File: tb/sdram_cmd_guard_test.sv
module sdram_cmd_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 2;
    localparam int TRP   = 3;
    localparam int TRRD  = 2;
    localparam int TRCD  = 3;
    localparam int TRMIN = 5;
    localparam int TRMAX = 24;
    localparam int TSUSP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [0:0] req_bank = 1'b0;
    logic susp_req = 1'b0;
    logic req_ready, issue_valid, cke, susp_over;
    logic [2:0] issue_cmd;
    logic [0:0] issue_bank;
    logic [NB-1:0] bank_open, ras_viol;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_guard #(
        .NUM_BANKS(NB), .T_RP(TRP), .T_RRD(TRRD), .T_RCD(TRCD),
        .T_RAS_MIN(TRMIN), .T_RAS_MAX(TRMAX), .T_SUSP_MAX(TSUSP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_ready(req_ready), .issue_valid(issue_valid),
        .issue_cmd(issue_cmd), .issue_bank(issue_bank), .susp_req(susp_req),
        .cke(cke), .susp_over(susp_over), .bank_open(bank_open), .ras_viol(ras_viol)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_open[NB];
    int m_act[NB];
    int m_pre[NB];
    int m_rrd, m_scnt;
    bit m_cke, m_lock, last_acc;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_act[b] = 0; m_pre[b] = TRP;
        end
        m_rrd = TRRD; m_cke = 1; m_lock = 0; m_scnt = 0;
    endtask

    function automatic bit exp_ready(int cmd, int b);
        if (!m_cke) return 0;
        case (cmd)
            1: return !m_open[b] && m_pre[b] >= TRP && m_rrd >= TRRD;
            2, 3: return m_open[b] && m_act[b] >= TRCD;
            4: return !m_open[b] || m_act[b] >= TRMIN;
            5, 6: return m_open[b] && m_act[b] >= TRCD && m_act[b] >= TRMIN;
            default: return 1;
        endcase
    endfunction

    function automatic string cmd_tag(int cmd);
        if (!m_cke) return "R7";
        case (cmd)
            1: return "R1 R2";
            2, 3: return "R3";
            4, 5, 6: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic step(bit v, int cmd, int b, bit s);
        bit er, acc, force_x;
        @(negedge clk);
        req_valid = v; req_cmd = 3'(cmd); req_bank = 1'(b); susp_req = s;
        #1;
        er = exp_ready(cmd, b);
        acc = v && er;
        check(cmd_tag(cmd), int'(req_ready), int'(er));
        check("R10 issue_valid", int'(issue_valid), int'(acc));
        if (acc) begin
            check("R10 issue_cmd", int'(issue_cmd), cmd);
            check("R10 issue_bank", int'(issue_bank), b);
        end
        check("R6 R8 cke", int'(cke), int'(m_cke));
        check("R8 susp_over", int'(susp_over), int'(m_lock));
        for (int i = 0; i < NB; i++) begin
            check("R5 ras_viol", int'(ras_viol[i]), int'(m_open[i] && m_act[i] >= TRMAX));
            check("R1 R4 bank_open", int'(bank_open[i]), int'(m_open[i]));
        end
        last_acc = acc;
        // advance model by one edge
        if (m_cke) begin
            for (int i = 0; i < NB; i++) begin
                bit sel = acc && (b == i);
                if (sel && cmd == 1) begin m_open[i] = 1; m_act[i] = 1; end
                else if (m_act[i] < TRMAX) m_act[i]++;
                if (sel && ((cmd == 4 && m_open[i]) || cmd == 5 || cmd == 6)) begin
                    m_open[i] = 0; m_pre[i] = 1;
                end else if (m_pre[i] < TRP) m_pre[i]++;
            end
            if (acc && cmd == 1) m_rrd = 1;
            else if (m_rrd < TRRD) m_rrd++;
        end
        force_x = !m_cke && s && (m_scnt == TSUSP - 1);
        m_scnt = m_cke ? 0 : m_scnt + 1;
        m_cke = !(s && !m_lock && !force_x);
        m_lock = force_x || (m_lock && s);
    endtask

    task automatic issue(int cmd, int b);
        for (int k = 0; k < 40; k++) begin
            step(1, cmd, b, 0);
            if (last_acc) return;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit hold_req, s_on;
        int wait_n, cv, cb, r;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 cke", int'(cke), 1);
        check("R9 bank_open", int'(bank_open), 0);
        check("R9 susp_over", int'(susp_over), 0);
        check("R9 ras_viol", int'(ras_viol), 0);
        rst_n = 1'b1;
        model_reset();

        // directed: R9 ACT granted at once, R2 second bank waits T_RRD
        step(1, 1, 0, 0);
        check("R9 act right after reset", int'(last_acc), 1);
        issue(1, 1);
        // R3 read at exactly T_RCD
        issue(2, 0);
        // R4 early precharge stalls then goes
        issue(4, 1);
        // R1 reopen waits T_RP
        issue(1, 1);
        issue(6, 1);
        // R5 keep bank 0 open past T_RAS_MAX
        for (int k = 0; k < TRMAX + 2; k++) step(0, 0, 0, 0);
        issue(4, 0);
        // R10 precharge to idle bank, reserved code
        issue(4, 0);
        step(1, 7, 1, 0);
        // R8 long suspend hits the limit and locks
        for (int k = 0; k < 2 * TSUSP + 4; k++) step(1, 0, 0, 1);
        step(0, 0, 0, 0);
        // R7 suspend with pending activate
        for (int k = 0; k < 3; k++) step(1, 1, 0, 1);
        for (int k = 0; k < 4; k++) step(1, 1, 0, 0);

        // constrained random phase
        hold_req = 0; s_on = 0; wait_n = 0; cv = 0; cb = 0;
        for (int n = 0; n < 4000; n++) begin
            if (s_on) s_on = ($urandom % 8) != 0;
            else      s_on = ($urandom % 12) == 0;
            if (!(hold_req && wait_n < 12)) begin
                r = $urandom % 16;
                case (r)
                    2, 3, 4:   cv = 1;
                    5, 6:      cv = 2;
                    7, 8:      cv = 3;
                    9, 10, 11: cv = 4;
                    12:        cv = 5;
                    13:        cv = 6;
                    14:        cv = 7;
                    default:   cv = 0;
                endcase
                cb = $urandom % NB;
                hold_req = ($urandom % 10) < 7;
                wait_n = 0;
            end
            step(hold_req, cv, cb, s_on);
            if (last_acc || !hold_req) hold_req = 0;
            else wait_n++;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule